// File: doc/BRIEF.md
# Prescaled Dual Down-Counter Timer

This block holds one shared 16-bit prescaler and two 32-bit down-counting timers behind a plain 32-bit register port. The prescaler divides the system clock. It emits one tick every (reload + 1) clocks. On every tick, each enabled timer counts down by one. When a timer steps past zero to all ones, it pulses its own interrupt line for one clock. If its auto-reload bit is set, it then restarts from its reload register; if not, it keeps counting down from all ones.

Software programs the block through a single-cycle write strobe with address and data. It reads through a combinational read address and data pair. Every register port is a plain control pin with no handshake, because the block neither accepts nor produces a data stream. Each access completes in the cycle it is presented and can never be held off.

Top module: `ptd_dual_timer`

## Requirements
- R1: A write to the prescaler reload register (offset 0x64) keeps only bits 15:0 of the data, and restarts the prescaler countdown from the new value on the same clock edge.
- R2: The prescaler value (offset 0x60) counts down by one per clock from the reload value to 0. The tick occurs in the cycle where it is 0, and the value returns to the reload value on the next edge, giving a period of reload + 1 clocks.
- R3: A timer counter changes by one per tick only while its enable bit (control bit 0) is set. While that bit is clear, the counter holds its value.
- R4: A control write stores data bits 0, 1 and 3, and bit 2 always reads back as 0. Writing bit 2 as 1 copies the timer's reload register into its counter on that edge.
- R5: An enabled timer whose counter is 0 when a tick occurs raises its interrupt output for exactly the one cycle after that tick edge. The timer at 0x40 drives irq bit 0, and the timer at 0x50 drives irq bit 1.
- R6: On that underflow, a timer with auto-reload (control bit 1) set loads its reload value. Otherwise its counter becomes 0xFFFFFFFF and it keeps counting down on later ticks.
- R7: After reset, the prescaler reload and value are 0xFFFF, both counters and both reload registers are 0xFFFFFFFF, and both control registers are 0.
- R8: Counter and reload registers take written data directly. A counter write in the same cycle as a tick wins over the decrement and suppresses that tick's underflow.
- R9: Timer n (n = 0, 1) has its counter at 0x40 + 0x10·n, its reload at +0x04 and its control at +0x08. Reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 2 | One-cycle underflow pulse per timer |

## Verification
Read data is combinational and reflects register state from the last clock edge. The bench samples each read 1 ns after a falling edge, one half-period after the write it depends on. A tick happens in the cycle where the prescaler reads 0, so a timer's new count and its interrupt pulse both appear right after the following rising edge. The bench therefore restarts the prescaler with a reload write, counts edges from that write, and samples counters and irq at exactly the falling edge after each expected tick edge. The scoreboard queues an expected channel before each predicted underflow and pops it when the monitor sees a pulse, so a missing, extra or misrouted pulse is reported.

// File: rtl/ptd_pkg.sv
package ptd_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int PS_W       = 16;
  localparam int CTL_W      = 4;

  localparam logic [ADDR_W-1:0] OFF_PS_VAL  = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_PS_RLD  = 8'h64;
  localparam logic [ADDR_W-1:0] OFF_T_BASE  = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_T_STEP  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_T_CNT   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_T_RLD   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_T_CTL   = 8'h08;

  localparam logic [CTL_W-1:0] CTL_KEEP = 4'hB;
  localparam int CTL_EN   = 0;
  localparam int CTL_AUTO = 1;
  localparam int CTL_LOAD = 2;
endpackage

// File: rtl/ptd_prescaler.sv
module ptd_prescaler #(
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rld_we,
  input  logic [PS_W-1:0] rld_wdata,
  output logic [PS_W-1:0] cnt_o,
  output logic [PS_W-1:0] rld_o,
  output logic            tick_o
);
  logic [PS_W-1:0] cnt_q, rld_q;

  assign tick_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '1;
      cnt_q <= '1;
    end else if (rld_we) begin
      rld_q <= rld_wdata;
      cnt_q <= rld_wdata;
    end else if (tick_o) begin
      cnt_q <= rld_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  ps_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= rld_q);

  // R2
  ps_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !rld_we) |=> (cnt_q == $past(rld_q)));
endmodule

// File: rtl/ptd_channel.sv
module ptd_channel
  import ptd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic             rld_we,
  input  logic             ctl_we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    cnt_o,
  output logic [DW-1:0]    rld_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             irq_o
);
  logic [DW-1:0]    cnt_q, rld_q;
  logic [CTL_W-1:0] ctl_q;
  logic             irq_q;
  logic             load_now, step, wrap;

  assign load_now = ctl_we && wdata[CTL_LOAD];
  assign step     = tick && ctl_q[CTL_EN];
  assign wrap     = step && (cnt_q == '0) && !cnt_we && !load_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      rld_q <= '1;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= wrap;
      if (rld_we) rld_q <= wdata;
      if (ctl_we) ctl_q <= wdata[CTL_W-1:0] & CTL_KEEP;
      if (cnt_we)            cnt_q <= wdata;
      else if (load_now)     cnt_q <= rld_q;
      else if (step) begin
        if (cnt_q == '0)     cnt_q <= ctl_q[CTL_AUTO] ? rld_q : '1;
        else                 cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = ctl_q;
  assign irq_o = irq_q;

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CTL_EN] && !cnt_we && !load_now) |=> (cnt_q == $past(cnt_q)));

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(tick && ctl_q[CTL_EN]));

  // R6
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ctl_q[CTL_AUTO] && !rld_we) |=> (cnt_q == rld_q));

  // R8
  cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(wdata) && !irq_q));
endmodule

// File: rtl/ptd_dual_timer.sv
module ptd_dual_timer
  import ptd_pkg::*;
#(
  parameter int NTMR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NTMR-1:0]   irq
);
  logic            tick;
  logic [PS_W-1:0] ps_cnt, ps_rld;

  logic [DATA_W-1:0] t_cnt [NTMR];
  logic [DATA_W-1:0] t_rld [NTMR];
  logic [CTL_W-1:0]  t_ctl [NTMR];

  ptd_prescaler #(.PS_W(PS_W)) u_ps (
    .clk       (clk),
    .rst_n     (rst_n),
    .rld_we    (wr_en && (wr_addr == OFF_PS_RLD)),
    .rld_wdata (wr_data[PS_W-1:0]),
    .cnt_o     (ps_cnt),
    .rld_o     (ps_rld),
    .tick_o    (tick)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] BASE = OFF_T_BASE + ADDR_W'(g) * OFF_T_STEP;
    ptd_channel #(.DW(DATA_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .cnt_we (wr_en && (wr_addr == BASE + OFF_T_CNT)),
      .rld_we (wr_en && (wr_addr == BASE + OFF_T_RLD)),
      .ctl_we (wr_en && (wr_addr == BASE + OFF_T_CTL)),
      .wdata  (wr_data),
      .cnt_o  (t_cnt[g]),
      .rld_o  (t_rld[g]),
      .ctl_o  (t_ctl[g]),
      .irq_o  (irq[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == OFF_PS_VAL) rd_data = DATA_W'(ps_cnt);
    if (rd_addr == OFF_PS_RLD) rd_data = DATA_W'(ps_rld);
    for (int i = 0; i < NTMR; i++) begin
      if (rd_addr == OFF_T_BASE + ADDR_W'(i) * OFF_T_STEP + OFF_T_CNT) rd_data = t_cnt[i];
      if (rd_addr == OFF_T_BASE + ADDR_W'(i) * OFF_T_STEP + OFF_T_RLD) rd_data = t_rld[i];
      if (rd_addr == OFF_T_BASE + ADDR_W'(i) * OFF_T_STEP + OFF_T_CTL) rd_data = DATA_W'(t_ctl[i]);
    end
  end

  // R4
  ctl_bit2_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == OFF_T_BASE + OFF_T_CTL) |-> (rd_data[CTL_LOAD] == 1'b0));
endmodule

// File: tb/ptd_dual_timer_tb.sv
module ptd_dual_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq;

  int tests = 0;
  int fails = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptd_dual_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // scoreboard monitor: every irq pulse must match the next queued channel
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        if (irq[i]) begin
          if (exp_q.size() == 0) check("R5 unexpected irq", 32'(i), 32'hFFFF_FFFF);
          else check("R5 irq channel", 32'(i), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset values
    rd("R7 ps reload", 8'h64, 32'h0000_FFFF);
    rd("R7 t0 cnt",    8'h40, 32'hFFFF_FFFF);
    rd("R7 t0 rld",    8'h44, 32'hFFFF_FFFF);
    rd("R7 t0 ctl",    8'h48, 32'h0);
    rd("R7 t1 cnt",    8'h50, 32'hFFFF_FFFF);
    rd("R7 t1 ctl",    8'h58, 32'h0);
    rd("R9 unmapped",  8'h70, 32'h0);

    // R1 mask and restart; R2 countdown and wrap
    wr(8'h64, 32'h0001_2345);
    rd("R1 reload mask", 8'h64, 32'h0000_2345);
    wr(8'h64, 32'd3);
    rd("R2 ps 3", 8'h60, 32'd3); @(negedge clk);
    rd("R2 ps 2", 8'h60, 32'd2); @(negedge clk);
    rd("R2 ps 1", 8'h60, 32'd1); @(negedge clk);
    rd("R2 ps 0", 8'h60, 32'd0); @(negedge clk);
    rd("R2 ps wrap", 8'h60, 32'd3);

    // timer 0 auto-reload: R4 load, R3 count, R5 pulse, R6 reload
    wr(8'h44, 32'd2);
    wr(8'h48, 32'h6);
    rd("R4 load now", 8'h40, 32'd2);
    rd("R4 ctl stored", 8'h48, 32'h2);
    wr(8'h64, 32'd3);
    wr(8'h48, 32'h3);
    exp_q.push_back(0);
    cyc(3); rd("R3 t0 step1", 8'h40, 32'd1);
    check("R5 no early irq", 32'(irq), 32'h0);
    cyc(4); rd("R3 t0 step2", 8'h40, 32'd0);
    cyc(4); rd("R6 t0 reloaded", 8'h40, 32'd2);
    check("R5 irq0 high", 32'(irq), 32'h1);
    wr(8'h48, 32'h0);
    check("R5 irq0 one cycle", 32'(irq), 32'h0);

    // timer 1 one-shot: R6 no reload, R5 routing
    wr(8'h54, 32'd0);
    wr(8'h64, 32'd3);
    wr(8'h58, 32'h5);
    exp_q.push_back(1);
    cyc(3); rd("R6 t1 all ones", 8'h50, 32'hFFFF_FFFF);
    check("R5 irq1 high", 32'(irq), 32'h2);
    cyc(4); rd("R6 t1 continues", 8'h50, 32'hFFFF_FFFE);
    rd("R4 ctl bit2 dropped", 8'h58, 32'h1);
    wr(8'h58, 32'hE);
    rd("R4 ctl 0xE stores 0xA", 8'h58, 32'hA);
    rd("R4 load from reload", 8'h50, 32'd0);
    cyc(12);
    rd("R3 disabled holds", 8'h50, 32'd0);

    // R8 counter write beats tick decrement
    wr(8'h64, 32'd3);
    wr(8'h48, 32'h1);
    cyc(2);
    wr(8'h40, 32'h100);
    rd("R8 write wins", 8'h40, 32'h100);
    cyc(4); rd("R3 decrement after write", 8'h40, 32'hFF);
    wr(8'h48, 32'h0);
    rd("R8 reload readback", 8'h44, 32'd2);

    cyc(4);
    check("R5 all expected irqs seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule